// File: doc/BRIEF.md
# Slow-Clock Frequency Meter

The block measures a slow clock, nominally 32.768 kHz, against a fast reference clock. Software enables the meter, programs a length N and issues a start. The slow domain then opens a gate lasting exactly (N+1) "seconds", where one second is `TICKS_PER_SEC` slow-clock cycles. The reference domain counts its own cycles while it sees the gate open. When the gate closes, the count is latched and a done flag is raised. With a 24 MHz reference and a perfect 32.768 kHz slow clock, the ideal result is 24,000,000 × (N+1).

Each signal that crosses between the domains goes through a two-flop synchroniser:
- the request, from the reference domain to the slow domain;
- the gate and the slow-side activity flag, from the slow domain back to the reference domain.

The length is captured when the start is accepted. It is held stable for as long as the request is up, so the slow domain can sample it safely. Software reads the result as byte registers.

Reference-domain FSM (`meter_count`):
- **R_IDLE** goes to **R_ARM** on an accepted start. A start is accepted only when it is written while the meter is enabled.
- **R_ARM** goes to **R_COUNT** when the synchronised gate is first seen high.
- **R_COUNT** goes to **R_RELEASE** when the synchronised gate falls. The count is latched and the request is dropped.
- **R_RELEASE** goes to **R_IDLE** when the slow side reports idle. Done is set on this transition.

Slow-domain FSM (`meter_window`):
- **W_IDLE** goes to **W_GATE** when the synchronised request is seen. The length is loaded.
- **W_GATE** goes to **W_HOLD** after (N+1)·`TICKS_PER_SEC` slow cycles.
- **W_HOLD** goes to **W_IDLE** when the request is gone.

`TICKS_PER_SEC` must be at least 4.

Top module: `slowclk_freq_meter`

## Requirements
- R1: After reset, the status register (address 2) reads 0 and all four result bytes (addresses 4 to 7) read 0.
- R2: Bit 0 of address 0 enables the meter. A start written while this bit is 0 is ignored, and busy stays 0.
- R3: Writing a 1 to bit 0 of address 2 starts a measurement. From the cycle after the write, busy reads 1 in bit 1 of address 2.
- R4: The length register at address 1 holds N. The result equals the number of reference cycles in (N+1)·`TICKS_PER_SEC` slow cycles, within ±1.
- R5: The result is little-endian. Address 4 holds bits 7:0, address 5 holds bits 15:8, address 6 holds bits 23:16 and address 7 holds bits 31:24. Bits above `CNT_W` read as 0.
- R6: At the end of a measurement, busy (bit 1) clears and done (bit 2 of address 2) sets in the same cycle. The latched result does not change in the cycle in which done rises.
- R7: An accepted start clears done and resets the counter. A second measurement reports its own window only and does not add to the first.
- R8: A start written while a measurement is busy is ignored. The measurement in progress completes with its original window.
- R9: The reference counter saturates at all-ones instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; also clocks the register interface |
| ref_rst_n | input | 1 | Asynchronous active-low reset, reference domain |
| slow_clk | input | 1 | Slow clock under measurement |
| slow_rst_n | input | 1 | Asynchronous active-low reset, slow domain |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |

## Verification
The bench runs windows of two lengths and compares the result against the cycle count computed from the two clock periods.
- A design that restarted its count on the ARM-to-COUNT edge would read one low.
- A design that failed to reset the counter on a new start would report roughly double on the second run.
- A start issued mid-window must leave the result unchanged. A design that re-armed on it would report a wrong result or hang.
- A second instance with an 8-bit counter and a long window must read 0xFF. A design that wrapped would show a small value.
- The start-with-enable-off case must leave busy at 0. A design that ignored the enable would show busy at 1.

// File: rtl/meter_pkg.sv
`timescale 1ns/1ps
package meter_pkg;
    localparam int ADDR_W    = 3;
    localparam int DATA_W    = 8;
    localparam int RES_BYTES = 4;

    localparam logic [ADDR_W-1:0] A_ENABLE = 3'd0;
    localparam logic [ADDR_W-1:0] A_LENGTH = 3'd1;
    localparam logic [ADDR_W-1:0] A_STATUS = 3'd2;
    localparam logic [ADDR_W-1:0] A_RES0   = 3'd4;

    typedef enum logic [1:0] {
        R_IDLE    = 2'd0,
        R_ARM     = 2'd1,
        R_COUNT   = 2'd2,
        R_RELEASE = 2'd3
    } ref_state_e;

    typedef enum logic [1:0] {
        W_IDLE = 2'd0,
        W_GATE = 2'd1,
        W_HOLD = 2'd2
    } win_state_e;
endpackage

// File: rtl/meter_sync2.sv
`timescale 1ns/1ps
module meter_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
        end else begin
            s1_q <= d;
            s2_q <= s1_q;
        end
    end

    assign q = s2_q;
endmodule

// File: rtl/meter_window.sv
`timescale 1ns/1ps
module meter_window #(
    parameter int TICKS_PER_SEC = 32768,
    parameter int LEN_W         = 8
) (
    input  logic             slow_clk,
    input  logic             slow_rst_n,
    input  logic             req_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             gate_o,
    output logic             act_o
);
    import meter_pkg::*;

    localparam int TICK_W = $clog2(TICKS_PER_SEC);
    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICKS_PER_SEC - 1);

    win_state_e       state_q, state_d;
    logic [TICK_W-1:0] tick_q;
    logic [LEN_W-1:0]  sec_q;
    logic [LEN_W-1:0]  len_q;
    logic              last_tick;

    assign last_tick = (tick_q == TICK_LAST) && (sec_q == '0);

    always_ff @(posedge slow_clk or negedge slow_rst_n) begin
        if (!slow_rst_n) state_q <= W_IDLE;
        else             state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        case (state_q)
            W_IDLE:  if (req_i)     state_d = W_GATE;
            W_GATE:  if (last_tick) state_d = W_HOLD;
            W_HOLD:  if (!req_i)    state_d = W_IDLE;
            default:                state_d = W_IDLE;
        endcase
    end

    always_ff @(posedge slow_clk or negedge slow_rst_n) begin
        if (!slow_rst_n) begin
            tick_q <= '0;
            sec_q  <= '0;
            len_q  <= '0;
        end else begin
            case (state_q)
                W_IDLE: if (req_i) begin
                    tick_q <= '0;
                    sec_q  <= len_i;
                    len_q  <= len_i;
                end
                W_GATE: begin
                    if (tick_q == TICK_LAST) begin
                        tick_q <= '0;
                        if (sec_q != '0) sec_q <= sec_q - 1'b1;
                    end else begin
                        tick_q <= tick_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        gate_o = (state_q == W_GATE);
        act_o  = (state_q != W_IDLE);
    end

    AST_SEC_BOUND: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
        (state_q == W_GATE) |-> (sec_q <= len_q)); // R4

    AST_LEN_HELD: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
        (state_q == W_GATE && $past(state_q) == W_GATE) |-> $stable(len_q)); // R4
endmodule

// File: rtl/meter_count.sv
`timescale 1ns/1ps
module meter_count #(
    parameter int CNT_W = 32,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             en_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             gate_i,
    input  logic             act_i,
    output logic             req_o,
    output logic [LEN_W-1:0] len_hold_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [CNT_W-1:0] result_o
);
    import meter_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    ref_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] result_q;
    logic             done_q;
    logic             req_q;
    logic [LEN_W-1:0] len_q;
    logic             accept;

    assign accept = (state_q == R_IDLE) && start_i && en_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= R_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            R_IDLE:    if (accept)  state_d = R_ARM;
            R_ARM:     if (gate_i)  state_d = R_COUNT;
            R_COUNT:   if (!gate_i) state_d = R_RELEASE;
            R_RELEASE: if (!act_i)  state_d = R_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            result_q <= '0;
            done_q   <= 1'b0;
            req_q    <= 1'b0;
            len_q    <= '0;
        end else begin
            unique case (state_q)
                R_IDLE: if (accept) begin
                    cnt_q  <= '0;
                    done_q <= 1'b0;
                    req_q  <= 1'b1;
                    len_q  <= len_i;
                end
                R_ARM: if (gate_i) cnt_q <= CNT_W'(1);
                R_COUNT: begin
                    if (gate_i) begin
                        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
                    end else begin
                        result_q <= cnt_q;
                        req_q    <= 1'b0;
                    end
                end
                R_RELEASE: if (!act_i) done_q <= 1'b1;
            endcase
        end
    end

    always_comb begin
        busy_o     = (state_q != R_IDLE);
        done_o     = done_q;
        req_o      = req_q;
        len_hold_o = len_q;
        result_o   = result_q;
    end

    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == R_COUNT && gate_i && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX)); // R9

    AST_RESULT_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $stable(result_q)); // R6

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == R_COUNT || state_q == R_RELEASE) && start_i) |=> (state_q != R_ARM)); // R8

    AST_DISABLED_STAY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == R_IDLE && !en_i) |=> (state_q == R_IDLE)); // R2

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (!done_q && cnt_q == '0)); // R7

    AST_LEN_STABLE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && $past(req_q)) |-> $stable(len_q)); // R4
endmodule

// File: rtl/meter_regs.sv
`timescale 1ns/1ps
module meter_regs
    import meter_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int LEN_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              en_o,
    output logic [LEN_W-1:0]  len_o,
    output logic              start_o,
    input  logic              busy_i,
    input  logic              done_i,
    input  logic [CNT_W-1:0]  result_i
);
    logic             en_q;
    logic [LEN_W-1:0] len_q;
    logic [31:0]      res_ext;
    logic [7:0]       res_byte [RES_BYTES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            len_q <= '0;
        end else if (wr_i) begin
            if (addr_i == A_ENABLE) en_q  <= wdata_i[0];
            if (addr_i == A_LENGTH) len_q <= LEN_W'(wdata_i);
        end
    end

    assign res_ext = 32'(result_i);

    for (genvar i = 0; i < RES_BYTES; i++) begin : g_byte
        assign res_byte[i] = res_ext[8*i +: 8];
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            A_ENABLE: rdata_o = {7'b0, en_q};
            A_LENGTH: rdata_o = DATA_W'(len_q);
            A_STATUS: rdata_o = {5'b0, done_i, busy_i, 1'b0};
            3'd4:     rdata_o = res_byte[0];
            3'd5:     rdata_o = res_byte[1];
            3'd6:     rdata_o = res_byte[2];
            3'd7:     rdata_o = res_byte[3];
            default:  rdata_o = '0;
        endcase
    end

    assign en_o    = en_q;
    assign len_o   = len_q;
    assign start_o = wr_i && (addr_i == A_STATUS) && wdata_i[0];

    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_i && done_i)); // R6
endmodule

// File: rtl/slowclk_freq_meter.sv
`timescale 1ns/1ps
module slowclk_freq_meter #(
    parameter int TICKS_PER_SEC = 32768,
    parameter int LEN_W         = 8,
    parameter int CNT_W         = 32
) (
    input  logic       ref_clk,
    input  logic       ref_rst_n,
    input  logic       slow_clk,
    input  logic       slow_rst_n,
    input  logic       reg_wr,
    input  logic [2:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata
);
    logic             en, start, busy, done;
    logic [LEN_W-1:0] len_reg, len_hold;
    logic [CNT_W-1:0] result;
    logic             req_ref, req_slow;
    logic             gate_slow, gate_ref;
    logic             act_slow, act_ref;

    meter_regs #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_regs (
        .clk(ref_clk), .rst_n(ref_rst_n),
        .wr_i(reg_wr), .addr_i(reg_addr), .wdata_i(reg_wdata), .rdata_o(reg_rdata),
        .en_o(en), .len_o(len_reg), .start_o(start),
        .busy_i(busy), .done_i(done), .result_i(result)
    );

    meter_count #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_count (
        .clk(ref_clk), .rst_n(ref_rst_n),
        .start_i(start), .en_i(en), .len_i(len_reg),
        .gate_i(gate_ref), .act_i(act_ref),
        .req_o(req_ref), .len_hold_o(len_hold),
        .busy_o(busy), .done_o(done), .result_o(result)
    );

    meter_sync2 u_sync_req  (.clk(slow_clk), .rst_n(slow_rst_n), .d(req_ref),   .q(req_slow));
    meter_sync2 u_sync_gate (.clk(ref_clk),  .rst_n(ref_rst_n),  .d(gate_slow), .q(gate_ref));
    meter_sync2 u_sync_act  (.clk(ref_clk),  .rst_n(ref_rst_n),  .d(act_slow),  .q(act_ref));

    meter_window #(.TICKS_PER_SEC(TICKS_PER_SEC), .LEN_W(LEN_W)) u_window (
        .slow_clk(slow_clk), .slow_rst_n(slow_rst_n),
        .req_i(req_slow), .len_i(len_hold),
        .gate_o(gate_slow), .act_o(act_slow)
    );
endmodule

// File: tb/slowclk_freq_meter_bench.sv
`timescale 1ns/1ps
module slowclk_freq_meter_bench;
    localparam int TICKS = 8;
    localparam int CYC_PER_SEC = 52; // 8 slow cycles of 130 ns over 20 ns

    logic ref_clk = 1'b0, slow_clk = 1'b0;
    logic ref_rst_n = 1'b0, slow_rst_n = 1'b0;
    logic wr = 1'b0, sel = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata_a, rdata_b, rdata;
    int checks = 0, errors = 0;

    always #10 ref_clk = ~ref_clk;
    always #65 slow_clk = ~slow_clk;

    slowclk_freq_meter #(.TICKS_PER_SEC(TICKS), .LEN_W(8), .CNT_W(32)) u_slowclk_freq_meter (
        .ref_clk(ref_clk), .ref_rst_n(ref_rst_n), .slow_clk(slow_clk), .slow_rst_n(slow_rst_n),
        .reg_wr(wr && !sel), .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata_a)
    );

    slowclk_freq_meter #(.TICKS_PER_SEC(TICKS), .LEN_W(8), .CNT_W(8)) u_sat (
        .ref_clk(ref_clk), .ref_rst_n(ref_rst_n), .slow_clk(slow_clk), .slow_rst_n(slow_rst_n),
        .reg_wr(wr && sel), .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata_b)
    );

    assign rdata = sel ? rdata_b : rdata_a;

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic s, input logic [2:0] a, input logic [7:0] d);
        @(negedge ref_clk);
        sel = s; addr = a; wdata = d; wr = 1'b1;
        @(negedge ref_clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic s, input logic [2:0] a, output logic [7:0] d);
        @(negedge ref_clk);
        sel = s; addr = a;
        #1 d = rdata;
    endtask

    task automatic wait_done(input logic s);
        logic [7:0] st;
        for (int i = 0; i < 20000; i++) begin
            rd_reg(s, 3'd2, st);
            if (st[2] && !st[1]) break;
        end
    endtask

    task automatic rd_result(input logic s, output logic [31:0] v);
        logic [7:0] b;
        v = '0;
        for (int i = 0; i < 4; i++) begin
            rd_reg(s, 3'(4 + i), b);
            v[8*i +: 8] = b;
        end
    endtask

    task automatic t_reset;
        logic [7:0] d;
        rd_reg(0, 3'd2, d);
        chk(d == 8'h00, "R1 status after reset", d, 0);
        for (int i = 0; i < 4; i++) begin
            rd_reg(0, 3'(4 + i), d);
            chk(d == 8'h00, "R1 result byte after reset", d, 0);
        end
    endtask

    task automatic t_disabled;
        logic [7:0] d;
        wr_reg(0, 3'd2, 8'h01);
        rd_reg(0, 3'd2, d);
        chk(d[1] == 1'b0, "R2 start with enable off ignored", d[1], 0);
        repeat (20) @(negedge ref_clk);
        rd_reg(0, 3'd2, d);
        chk(d == 8'h00, "R2 still idle", d, 0);
    endtask

    task automatic t_measure(input int n, input string tag);
        logic [7:0] d;
        logic [31:0] v;
        int exp;
        exp = CYC_PER_SEC * (n + 1);
        wr_reg(0, 3'd1, 8'(n));
        wr_reg(0, 3'd2, 8'h01);
        rd_reg(0, 3'd2, d);
        chk(d[1] == 1'b1 && d[2] == 1'b0, "R3 R7 busy set done cleared after start", d, 2);
        wait_done(0);
        rd_reg(0, 3'd2, d);
        chk(d == 8'h04, "R6 done set busy clear", d, 4);
        rd_result(0, v);
        chk(int'(v) >= exp - 1 && int'(v) <= exp + 1, tag, int'(v), exp);
    endtask

    task automatic t_bytes;
        logic [7:0] b;
        // N=40: 2132 cycles -> byte1 = 0x08, bytes 2,3 = 0
        t_measure(40, "R4 R5 result N=40");
        rd_reg(0, 3'd5, b);
        chk(b == 8'h08, "R5 byte1", b, 8);
        rd_reg(0, 3'd6, b);
        chk(b == 8'h00, "R5 byte2", b, 0);
        rd_reg(0, 3'd7, b);
        chk(b == 8'h00, "R5 byte3", b, 0);
    endtask

    task automatic t_busy_restart;
        logic [31:0] v;
        int exp;
        exp = CYC_PER_SEC * 6;
        wr_reg(0, 3'd1, 8'd5);
        wr_reg(0, 3'd2, 8'h01);
        repeat (100) @(negedge ref_clk);
        wr_reg(0, 3'd1, 8'd1);
        wr_reg(0, 3'd2, 8'h01);
        wait_done(0);
        rd_result(0, v);
        chk(int'(v) >= exp - 1 && int'(v) <= exp + 1, "R8 start while busy ignored", int'(v), exp);
    endtask

    task automatic t_saturate;
        logic [31:0] v;
        wr_reg(1, 3'd0, 8'h01);
        wr_reg(1, 3'd1, 8'd9);
        wr_reg(1, 3'd2, 8'h01);
        wait_done(1);
        rd_result(1, v);
        chk(v == 32'h0000_00FF, "R9 saturated count", int'(v), 255);
    endtask

    initial begin
        repeat (150000) @(posedge ref_clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100;
        ref_rst_n = 1'b1;
        slow_rst_n = 1'b1;
        t_reset();
        t_disabled();
        wr_reg(0, 3'd0, 8'h01);
        t_measure(3, "R4 result N=3");
        t_measure(0, "R4 R7 result N=0 after previous run");
        t_bytes();
        t_busy_restart();
        t_saturate();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule